// File: doc/BRIEF.md
# Memory-Mapped Register Slave with One-Hot Decode

This block is a slave on an AHB-Lite bus that holds four 32-bit registers in a 16-byte window. In the address phase it registers the transfer attributes and a one-hot register select decoded from the address. In the following data phase it writes the enabled byte lanes of the selected register, or drives that register onto the read data bus.

The registered select drives both the register file and a debug output, so its shape and timing can be observed at the pins. Decoding happens in the address phase, and the data phase then works only from registered state. The ready output does not depend on the select in any way, and the read path combines registers with an AND-OR rather than a priority mux. A corrupted select pattern therefore cannot stall the bus or hang a transfer.

Top module: `ahb_reg_slave`

## Requirements
- R1: With hsel_i low, no address phase is accepted: the next cycle shows dbg_sel_o = 0 and no register changes, whatever the other inputs are.
- R2: Transfer types are encoded IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10, SEQ=2'b11. NONSEQ and SEQ start an access. IDLE and BUSY access nothing and get a zero-wait OKAY. The burst type, SINGLE=3'b000 or INCR=3'b001, does not change behaviour.
- R3: Sizes are encoded byte=3'b000, halfword=3'b001, word=3'b010. A byte write updates lane haddr_i[1:0]. A halfword write updates lanes {haddr_i[1],0} and {haddr_i[1],1}. A word write updates all four lanes. Lane k is hwdata_i[8k+7:8k].
- R4: dbg_sel_o never has more than one bit set.
- R5: dbg_sel_o is non-zero exactly in the cycle after an accepted in-range address phase, and is zero in every other cycle. This includes back-to-back transfers, where it stays set without a gap.
- R6: The window is 0xF000..0xF00F. Register i sits at 0xF000+4*i, and its select code is 1<<i, so 0xF000 gives 4'b0001 and 0xF00C gives 4'b1000.
- R7: An address outside the window gives dbg_sel_o = 0 and read data of zero, leaves every register unchanged on a write, and gets OKAY.
- R8: hrdata_o carries the full 32-bit value of the selected register during the data phase of a read, and is zero whenever dbg_sel_o is zero.
- R9: hready_o is low while rst_ni is low and high from the first clock edge after reset is released. hresp_o is always 0 (OKAY).
- R10: Reset clears all registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hsel_i | input | 1 | Slave select |
| haddr_i | input | 16 | Byte address |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | 1 = write, 0 = read |
| hsize_i | input | 3 | Transfer size |
| hburst_i | input | 3 | Burst type (no effect) |
| hready_i | input | 1 | Bus ready, previous transfer complete |
| hwdata_i | input | 32 | Write data, data phase |
| hrdata_o | output | 32 | Read data, data phase |
| hready_o | output | 1 | Slave ready |
| hresp_o | output | 1 | Response, always OKAY |
| dbg_sel_o | output | 4 | Registered register select |

## Verification
The assertions assume that the bus master follows AHB-Lite: hready_i reflects this slave's own hready_o, and data-phase write data arrives in the cycle after its address phase. They also assume that byte and halfword transfers are naturally aligned. The stimulus enforces these assumptions by feeding hready_o back as hready_i and by driving every address phase and its write data one cycle apart on the falling edge. Size and offset sweeps use aligned offsets only. One INCR burst puts a BUSY cycle between two SEQ beats, to cover the case where the select must drop for the BUSY cycle and then return.

// File: rtl/ahb_reg_pkg.sv
package ahb_reg_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] SZ_BYTE = 3'b000;
  localparam logic [2:0] SZ_HALF = 3'b001;
  localparam logic [2:0] SZ_WORD = 3'b010;
endpackage

// File: rtl/ahb_reg_decode.sv
module ahb_reg_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_REGS  = 4,
  parameter logic [15:0] BASE_ADDR = 16'hF000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                hit_o,
  output logic [NUM_REGS-1:0] sel_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam int unsigned TAG_LO = IDX_W + 2;

  logic unused_low;
  assign unused_low = ^addr_i[1:0];

  assign hit_o = (addr_i[ADDR_W-1:TAG_LO] == BASE_ADDR[ADDR_W-1:TAG_LO]);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel_o[i] = hit_o && (addr_i[TAG_LO-1:2] == IDX_W'(i));
  end

  // R6: an in-window address maps to exactly one register
  p_map_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $onehot(sel_o));
  p_miss_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (sel_o == '0));
endmodule

// File: rtl/ahb_reg_aphase.sv
module ahb_reg_aphase
  import ahb_reg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hsel_i,
  input  logic [1:0]          htrans_i,
  input  logic                hwrite_i,
  input  logic [2:0]          hsize_i,
  input  logic [1:0]          lane_i,
  input  logic                hready_i,
  input  logic [NUM_REGS-1:0] sel_next_i,
  output logic                dphase_o,
  output logic                write_o,
  output logic [DATA_W/8-1:0] be_o,
  output logic [NUM_REGS-1:0] sel_o
);
  localparam int unsigned NB = DATA_W / 8;
  localparam int unsigned LB = $clog2(NB);

  logic          accept;
  logic [NB-1:0] be_next;

  assign accept = hsel_i && hready_i &&
                  ((htrans_i == TR_NONSEQ) || (htrans_i == TR_SEQ));

  // lane b is enabled when it falls in the same size-aligned block as the address
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      if (hsize_i >= 3'(LB)) be_next[b] = 1'b1;
      else be_next[b] = ((b >> hsize_i) == (int'(lane_i) >> hsize_i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dphase_o <= 1'b0;
      write_o  <= 1'b0;
      be_o     <= '0;
      sel_o    <= '0;
    end else begin
      dphase_o <= accept;
      write_o  <= accept && hwrite_i;
      be_o     <= accept ? be_next : '0;
      sel_o    <= accept ? sel_next_i : '0;
    end
  end

  p_sel_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  p_sel_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (sel_next_i != '0)) |=> (sel_o != '0));
  p_sel_close_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> (sel_o == '0));
  p_unsel_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsel_i |=> !dphase_o);
  p_idle_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !htrans_i[1] |=> !dphase_o);
endmodule

// File: rtl/ahb_reg_file.sv
module ahb_reg_file #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] sel_i,
  input  logic                we_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int unsigned NB = DATA_W / 8;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[r] <= '0;
      end else if (we_i && sel_i[r]) begin
        for (int b = 0; b < NB; b++) begin
          if (be_i[b]) regs_q[r][8*b +: 8] <= wdata_i[8*b +: 8];
        end
      end
    end
  end

  // AND-OR read: a multi-hot select merges values, never blocks
  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      rdata_o = rdata_o | (regs_q[r] & {DATA_W{sel_i[r]}});
    end
  end

  p_hold_nowrite_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q));
  p_hold_nosel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |=> $stable(regs_q));
endmodule

// File: rtl/ahb_reg_slave.sv
module ahb_reg_slave
  import ahb_reg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_REGS  = 4,
  parameter logic [15:0] BASE_ADDR = 16'hF000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hsel_i,
  input  logic [ADDR_W-1:0]   haddr_i,
  input  logic [1:0]          htrans_i,
  input  logic                hwrite_i,
  input  logic [2:0]          hsize_i,
  input  logic [2:0]          hburst_i,
  input  logic                hready_i,
  input  logic [DATA_W-1:0]   hwdata_i,
  output logic [DATA_W-1:0]   hrdata_o,
  output logic                hready_o,
  output logic                hresp_o,
  output logic [NUM_REGS-1:0] dbg_sel_o
);
  localparam int unsigned NB = DATA_W / 8;

  logic                unused_burst;
  logic                hit;
  logic [NUM_REGS-1:0] sel_next;
  logic [NUM_REGS-1:0] sel_q;
  logic                dphase;
  logic                write_q;
  logic [NB-1:0]       be_q;
  logic                ready_q;

  assign unused_burst = ^hburst_i;

  ahb_reg_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(haddr_i),
    .hit_o (hit),
    .sel_o (sel_next)
  );

  ahb_reg_aphase #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
  ) u_aphase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hsel_i    (hsel_i),
    .htrans_i  (htrans_i),
    .hwrite_i  (hwrite_i),
    .hsize_i   (hsize_i),
    .lane_i    (haddr_i[1:0]),
    .hready_i  (hready_i),
    .sel_next_i(sel_next),
    .dphase_o  (dphase),
    .write_o   (write_q),
    .be_o      (be_q),
    .sel_o     (sel_q)
  );

  ahb_reg_file #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
  ) u_file (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_q),
    .we_i   (write_q),
    .be_i   (be_q),
    .wdata_i(hwdata_i),
    .rdata_o(hrdata_o)
  );

  // ready is independent of the select path: no pattern can stall the bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  assign hready_o  = ready_q;
  assign hresp_o   = 1'b0;
  assign dbg_sel_o = sel_q;

  p_ready_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> hready_o);
  p_resp_okay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hresp_o);
  p_rdata_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_sel_o == '0) |-> (hrdata_o == '0));
  p_sel_in_dphase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_sel_o != '0) |-> dphase);
  p_miss_no_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> (dbg_sel_o == '0));
endmodule

// File: tb/ahb_reg_slave_bench.sv
module ahb_reg_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0;
  logic [15:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'b010;
  logic [2:0]  hburst = 3'b000;
  logic        hready_in;
  logic [31:0] hwdata = '0;
  logic [31:0] hrdata;
  logic        hready;
  logic        hresp;
  logic [3:0]  dbg_sel;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_regs [4];
  logic [3:0]  obs_sel;
  logic [31:0] obs_rd;
  logic        obs_rdy;
  logic        obs_resp;

  always #4 clk = ~clk;
  assign hready_in = hready;

  ahb_reg_slave u_ahb_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .hsel_i(hsel), .haddr_i(haddr),
    .htrans_i(htrans), .hwrite_i(hwrite), .hsize_i(hsize), .hburst_i(hburst),
    .hready_i(hready_in), .hwdata_i(hwdata), .hrdata_o(hrdata),
    .hready_o(hready), .hresp_o(hresp), .dbg_sel_o(dbg_sel)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] map_sel(input logic [15:0] a);
    if (a[15:4] == 12'hF00) return 4'(1 << a[3:2]);
    return 4'b0000;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [2:0] sz, input logic [1:0] off);
    int nbytes = 1 << sz;
    int first = (int'(off) / nbytes) * nbytes;
    logic [31:0] m = '0;
    if (sz >= 3'd2) return 32'hFFFF_FFFF;
    for (int b = first; b < first + nbytes; b++) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  // sample the current data phase at negedge, then drive the next address phase
  task automatic step(input logic s, input logic [1:0] t, input logic [15:0] a,
                      input logic w, input logic [2:0] sz, input logic [31:0] wd);
    @(negedge clk);
    obs_sel = dbg_sel; obs_rd = hrdata; obs_rdy = hready; obs_resp = hresp;
    hsel = s; htrans = t; haddr = a; hwrite = w; hsize = sz; hwdata = wd;
  endtask

  task automatic xfer_write(input logic s, input logic [1:0] t, input logic [15:0] a,
                            input logic [2:0] sz, input logic [31:0] d, input string req);
    logic [3:0] es;
    logic [31:0] m;
    step(s, t, a, 1'b1, sz, 32'h0);
    step(1'b0, 2'b00, 16'h0, 1'b0, 3'b010, d);
    es = (s && t[1]) ? map_sel(a) : 4'b0000;
    chk(obs_sel == es, req, {28'h0, obs_sel}, {28'h0, es});
    chk(obs_rdy && !obs_resp, "R9", {30'h0, obs_rdy, obs_resp}, 32'h2);
    if (es != 0) begin
      m = lane_mask(sz, a[1:0]);
      exp_regs[a[3:2]] = (exp_regs[a[3:2]] & ~m) | (d & m);
    end
  endtask

  task automatic xfer_read(input logic [15:0] a, input string req);
    logic [3:0] es;
    logic [31:0] ed;
    step(1'b1, 2'b10, a, 1'b0, 3'b010, 32'h0);
    step(1'b0, 2'b00, 16'h0, 1'b0, 3'b010, 32'h0);
    es = map_sel(a);
    ed = (es != 0) ? exp_regs[a[3:2]] : 32'h0;
    chk(obs_sel == es, req, {28'h0, obs_sel}, {28'h0, es});
    chk(obs_rd == ed, req, obs_rd, ed);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) exp_regs[i] = 32'h0;
    #1;
    chk(hready == 1'b0, "R9 ready low in reset", {31'h0, hready}, 32'h0);
    chk(dbg_sel == 4'h0, "R5 sel idle in reset", {28'h0, dbg_sel}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hready == 1'b1, "R9 ready after reset", {31'h0, hready}, 32'h1);

    // R10 reset values, R6 address map
    for (int i = 0; i < 4; i++) xfer_read(16'hF000 + 16'(4*i), "R10 reset value");
    for (int i = 0; i < 4; i++)
      xfer_write(1'b1, 2'b10, 16'hF000 + 16'(4*i), 3'b010, 32'hA5000000 + 32'(i * 32'h01010101), "R6 map");
    for (int i = 0; i < 4; i++) xfer_read(16'hF000 + 16'(4*i), "R8 read back");

    // R3 size/offset sweep, aligned offsets
    for (int r = 0; r < 4; r++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off += (1 << sz)) begin
          xfer_write(1'b1, 2'b10, 16'hF000 + 16'(4*r + off), 3'(sz),
                     32'h11223344 ^ 32'(r * 32'h0F0F0F0F) ^ 32'(sz << 8) ^ 32'(off << 20), "R3 size lanes");
          xfer_read(16'hF000 + 16'(4*r), "R3 lane readback");
        end

    // R1 unselected writes
    for (int r = 0; r < 4; r++) xfer_write(1'b0, 2'b10, 16'hF000 + 16'(4*r), 3'b010, 32'hDEADBEEF, "R1 unselected");
    for (int r = 0; r < 4; r++) xfer_read(16'hF000 + 16'(4*r), "R1 unchanged");

    // R2 IDLE/BUSY, SINGLE burst
    for (int r = 0; r < 4; r++) begin
      xfer_write(1'b1, 2'b00, 16'hF000 + 16'(4*r), 3'b010, 32'hCAFEF00D, "R2 idle");
      xfer_write(1'b1, 2'b01, 16'hF000 + 16'(4*r), 3'b010, 32'hCAFEF00D, "R2 busy");
    end
    for (int r = 0; r < 4; r++) xfer_read(16'hF000 + 16'(4*r), "R2 unchanged");

    // R7 out of range
    xfer_write(1'b1, 2'b10, 16'hF010, 3'b010, 32'h55555555, "R7 miss write");
    xfer_write(1'b1, 2'b10, 16'hE000, 3'b010, 32'h66666666, "R7 miss write");
    xfer_write(1'b1, 2'b10, 16'h0000, 3'b000, 32'h77777777, "R7 miss write");
    xfer_read(16'hF010, "R7 miss read zero");
    xfer_read(16'h7000, "R7 miss read zero");
    for (int r = 0; r < 4; r++) xfer_read(16'hF000 + 16'(4*r), "R7 regs unchanged");

    // R5/R2 pipelined INCR burst with a BUSY beat
    hburst = 3'b001;
    step(1'b1, 2'b10, 16'hF000, 1'b1, 3'b010, 32'h0);
    step(1'b1, 2'b01, 16'hF004, 1'b1, 3'b010, 32'h10000001);
    chk(obs_sel == 4'b0001, "R5 burst beat0", {28'h0, obs_sel}, 32'h1);
    exp_regs[0] = 32'h10000001;
    step(1'b1, 2'b11, 16'hF004, 1'b1, 3'b010, 32'hFFFFFFFF);
    chk(obs_sel == 4'b0000, "R2 burst busy gap", {28'h0, obs_sel}, 32'h0);
    step(1'b1, 2'b11, 16'hF008, 1'b1, 3'b010, 32'h20000002);
    chk(obs_sel == 4'b0010, "R5 burst beat1", {28'h0, obs_sel}, 32'h2);
    exp_regs[1] = 32'h20000002;
    step(1'b1, 2'b11, 16'hF00C, 1'b1, 3'b010, 32'h30000003);
    chk(obs_sel == 4'b0100, "R5 burst beat2", {28'h0, obs_sel}, 32'h4);
    exp_regs[2] = 32'h30000003;
    step(1'b0, 2'b00, 16'h0, 1'b0, 3'b010, 32'h40000004);
    chk(obs_sel == 4'b1000, "R5 burst beat3", {28'h0, obs_sel}, 32'h8);
    exp_regs[3] = 32'h40000004;
    step(1'b0, 2'b00, 16'h0, 1'b0, 3'b010, 32'h0);
    chk(obs_sel == 4'b0000, "R5 window closed", {28'h0, obs_sel}, 32'h0);
    // pipelined read burst
    step(1'b1, 2'b10, 16'hF000, 1'b0, 3'b010, 32'h0);
    for (int i = 0; i < 4; i++) begin
      if (i < 3) step(1'b1, 2'b11, 16'hF000 + 16'(4*(i+1)), 1'b0, 3'b010, 32'h0);
      else       step(1'b0, 2'b00, 16'h0, 1'b0, 3'b010, 32'h0);
      chk(obs_sel == 4'(1 << i), "R4 burst read sel", {28'h0, obs_sel}, 32'(1 << i));
      chk(obs_rd == exp_regs[i], "R8 burst read data", obs_rd, exp_regs[i]);
    end
    hburst = 3'b000;
    step(1'b0, 2'b00, 16'h0, 1'b0, 3'b010, 32'h0);
    chk(obs_sel == 4'b0000 && obs_rd == 32'h0, "R8 idle read zero", obs_rd, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule